// File: doc/BRIEF.md
# Field-Gated Active-Video Byte Streamer

This block takes a stream of 4:2:2 video samples, each holding one luma byte and one chroma byte, and passes on only the samples that belong to the visible part of a line in the fields chosen for capture. Accepted samples go into a 32-entry FIFO. On every clock, the FIFO is drained onto an 8-bit output. Each stored sample leaves as two consecutive bytes, chroma first and then luma. A pair of pixels therefore comes out in the order Cb, Y0, Cr, Y1. A strobe marks each byte as it is presented.

A 3-bit field control code sets the capture rate: no capture, one field in four, every other field, or every field. A two-bit field counter starts at zero at reset and advances on every field-start marker. The capture decision is taken at each field start from the code and the counter, and it holds until the next field start. When the producer outruns the drain and the FIFO is full, the extra samples are dropped and a sticky overflow flag is raised.

Top module: `field_burst_out`

## Requirements
- R1: After reset, out_valid and overflow are low, the FIFO is empty, the field counter is zero and capture is off until the first field start.
- R2: A sample is stored only in a cycle where in_valid and in_active are both high inside a captured field. Any other sample produces no output byte.
- R3: Each stored sample is emitted as two bytes on consecutive clocks, first in_chroma and then in_luma. Bits [15:8] of an entry hold chroma and bits [7:0] hold luma.
- R4: Stored samples leave in the order they arrived, and no more than DEPTH (32) samples are ever held.
- R5: out_valid is high only in a cycle where out_byte carries a byte. While the FIFO is not empty, one byte is presented every clock. A sample accepted at edge k with an empty FIFO shows its first byte after edge k+1.
- R6: Field control codes 000 and 1xx capture nothing.
- R7: Code 011 captures every field.
- R8: Code 010 captures a field when the counter value at its start is even. The counter counts every field start since reset, starting from 0.
- R9: Code 001 captures a field when the counter value at its start is 0.
- R10: The capture decision is made in the field-start cycle and held for the whole field. Changing the control code mid-field has no effect until the next field start.
- R11: A sample that arrives while 32 entries are held is dropped, even if a read happens in the same cycle. The drop sets overflow, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present |
| in_active | input | 1 | Sample lies in the visible part of the line |
| in_field_start | input | 1 | Marks the first cycle of a field |
| in_luma | input | 8 | Luma byte of the sample |
| in_chroma | input | 8 | Chroma byte of the sample (Cb and Cr alternating) |
| fld_ctl | input | 3 | Field capture rate code |
| out_byte | output | 8 | Output byte |
| out_valid | output | 1 | out_byte holds a byte this cycle |
| overflow | output | 1 | Sticky flag: a sample was dropped because the FIFO was full |

## Verification
The assertions assume that in_field_start is never high in the same cycle as a valid active sample, and that fld_ctl changes only between clock edges. The stimulus keeps to this: each field-start marker is driven in a cycle of its own with in_valid low, and all inputs are driven on the falling edge. Before the overflow case, the stimulus waits until the FIFO has fully drained. It then sends back-to-back samples, so the first drop lands at a sample position that can be predicted. The field counter is tracked in the bench from the count of field starts it has driven.

// File: rtl/field_burst_out.sv
module field_burst_out #(
  parameter int DEPTH = 32,
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         in_active,
  input  logic         in_field_start,
  input  logic [W-1:0] in_luma,
  input  logic [W-1:0] in_chroma,
  input  logic [2:0]   fld_ctl,
  output logic [W-1:0] out_byte,
  output logic         out_valid,
  output logic         overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [2*W-1:0] mem [DEPTH];
  logic [AW-1:0]  wptr, rptr;
  logic [CW-1:0]  cnt;
  logic [1:0]     fcnt;
  logic           cap, half, pick;

  always_comb begin
    case (fld_ctl)
      3'b011:  pick = 1'b1;
      3'b010:  pick = ~fcnt[0];
      3'b001:  pick = (fcnt == 2'd0);
      default: pick = 1'b0;
    endcase
  end

  wire cap_now = in_field_start ? pick : cap;
  wire wr_req  = in_valid & in_active & cap_now;
  wire full    = (cnt == CW'(DEPTH));
  wire wr_ok   = wr_req & ~full;
  wire has     = (cnt != '0);
  wire rd_pop  = has & half;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= {in_chroma, in_luma};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fcnt      <= '0;
      cap       <= 1'b0;
      wptr      <= '0;
      rptr      <= '0;
      cnt       <= '0;
      half      <= 1'b0;
      out_valid <= 1'b0;
      out_byte  <= '0;
      overflow  <= 1'b0;
    end else begin
      if (in_field_start) begin
        cap  <= pick;
        fcnt <= fcnt + 2'd1;
      end
      if (wr_ok)  wptr <= wptr + AW'(1);
      if (rd_pop) rptr <= rptr + AW'(1);
      cnt <= cnt + CW'(wr_ok) - CW'(rd_pop);
      if (wr_req && full) overflow <= 1'b1;
      out_valid <= has;
      if (has) begin
        out_byte <= half ? mem[rptr][W-1:0] : mem[rptr][2*W-1:W];
        half     <= ~half;
      end
    end
  end
endmodule

module field_burst_out_chk #(
  parameter int DEPTH = 32,
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_field_start,
  input logic [2:0]    fld_ctl,
  input logic [CW-1:0] cnt,
  input logic          half,
  input logic          cap,
  input logic          out_valid,
  input logic          overflow
);
  // R11
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R11
  overflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> ($past(cnt) == CW'(DEPTH)) && $past(in_valid));

  // R4
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R3
  luma_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && half) |=> out_valid);

  // R2
  no_write_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> cnt <= $past(cnt));

  // R6
  no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_field_start && fld_ctl == 3'b000) |=> !cap);
endmodule

bind field_burst_out field_burst_out_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_field_start(in_field_start),
  .fld_ctl(fld_ctl), .cnt(cnt), .half(half), .cap(cap),
  .out_valid(out_valid), .overflow(overflow)
);

// File: tb/tb_field_burst_out.sv
module tb_field_burst_out;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_active = 1'b0, in_field_start = 1'b0;
  logic [7:0] in_luma = '0, in_chroma = '0;
  logic [2:0] fld_ctl = '0;
  logic [7:0] out_byte;
  logic out_valid, overflow;

  always #10 clk = ~clk;

  field_burst_out dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_active(in_active),
    .in_field_start(in_field_start), .in_luma(in_luma), .in_chroma(in_chroma),
    .fld_ctl(fld_ctl), .out_byte(out_byte), .out_valid(out_valid), .overflow(overflow)
  );

  logic [7:0] expq[$];
  int checks = 0, bad = 0, fcnt_m = 0;
  bit cap_m = 0, done = 0;
  string req = "R1";

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (expq.size() == 0) begin
        bad++;
        $display("FAIL %s/R5 actual=byte %0d expected=no byte", req, out_byte);
      end else begin
        logic [7:0] e;
        e = expq.pop_front();
        if (out_byte != e) begin
          bad++;
          $display("FAIL %s/R3 actual=%0d expected=%0d", req, out_byte, e);
        end
      end
    end
  end

  function automatic bit pick_m(logic [2:0] code, int f);
    case (code)
      3'b011: return 1'b1;
      3'b010: return (f % 2) == 0;
      3'b001: return f == 0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic field(logic [2:0] code);
    fld_ctl = code; in_field_start = 1'b1; in_valid = 1'b0;
    cap_m = pick_m(code, fcnt_m);
    fcnt_m = (fcnt_m + 1) % 4;
    @(negedge clk);
    in_field_start = 1'b0;
  endtask

  task automatic put(bit v, bit a, logic [7:0] y, logic [7:0] c, bit keep = 1'b1);
    in_valid = v; in_active = a; in_luma = y; in_chroma = c;
    if (v && a && cap_m && keep) begin
      expq.push_back(c);
      expq.push_back(y);
    end
    @(negedge clk);
    in_valid = 1'b0; in_active = 1'b0;
  endtask

  task automatic drain(string r);
    repeat (120) @(negedge clk);
    chk({r, " drained"}, expq.size(), 0);
  endtask

  task automatic t_reset();
    req = "R1";
    chk("R1 out_valid", out_valid, 0);
    chk("R1 overflow", overflow, 0);
  endtask

  task automatic t_every_field();
    req = "R7";
    field(3'b011);
    put(1, 1, 8'h10, 8'h80);
    chk("R5 no byte yet", out_valid, 0);
    @(negedge clk);
    chk("R5 first byte after k+1", out_valid, 1);
    chk("R3 chroma first", out_byte, 8'h80);
    put(1, 1, 8'h11, 8'hA0);
    put(1, 0, 8'h55, 8'h55);
    put(0, 1, 8'h66, 8'h66);
    put(1, 1, 8'h12, 8'h81);
    put(1, 1, 8'h13, 8'hA1);
    drain("R7");
  endtask

  task automatic t_gate_active();
    req = "R2";
    field(3'b011);
    for (int i = 0; i < 12; i++) put(i % 3 != 0, i % 2 == 0, 8'(i + 32), 8'(i + 64));
    drain("R2");
  endtask

  task automatic t_none();
    req = "R6";
    for (int f = 0; f < 2; f++) begin
      field(f == 0 ? 3'b000 : 3'b110);
      for (int i = 0; i < 4; i++) put(1, 1, 8'(i), 8'(i + 1));
    end
    drain("R6");
  endtask

  task automatic t_rate(logic [2:0] code, string r);
    req = r;
    for (int f = 0; f < 8; f++) begin
      field(code);
      for (int i = 0; i < 3; i++) put(1, 1, 8'(f * 16 + i), 8'(f * 16 + i + 128));
      repeat (4) @(negedge clk);
    end
    drain(r);
  endtask

  task automatic t_hold();
    req = "R10";
    field(3'b011);
    put(1, 1, 8'h21, 8'h91);
    fld_ctl = 3'b000;
    put(1, 1, 8'h22, 8'h92);
    field(3'b000);
    put(1, 1, 8'h23, 8'h93);
    fld_ctl = 3'b011;
    put(1, 1, 8'h24, 8'h94);
    drain("R10");
  endtask

  task automatic t_overflow();
    req = "R11";
    chk("R11 flag clear before", overflow, 0);
    field(3'b011);
    for (int n = 0; n < 70; n++) begin
      put(1, 1, 8'(n), 8'(n + 100), !(n >= 62 && n % 2 == 0));
      if (n == 61) chk("R11 not yet", overflow, 0);
      if (n == 62) chk("R11 set on drop", overflow, 1);
    end
    drain("R4/R11");
    chk("R11 sticky", overflow, 1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    fcnt_m = 0; cap_m = 0;
    chk("R1 overflow cleared", overflow, 0);
    chk("R1 out_valid after reset", out_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_every_field();
    t_gate_active();
    t_none();
    t_rate(3'b010, "R8");
    t_rate(3'b001, "R9");
    t_hold();
    t_overflow();
    req = "R7";
    field(3'b011);
    put(1, 1, 8'h42, 8'hC2);
    drain("R7");
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule